// File: doc/BRIEF.md
# Linear Circuit-Switched Stream Switch Node

This block is one node in a chain of identical switches that sets up dedicated streaming paths between producers and consumers. Each node knows its own index in the chain. A request arrives on a local input port, on a channel from the left neighbour or on a channel from the right neighbour. The node compares the requested destination index with its own index. It then claims a free outgoing lane in the matching direction and passes the request on. When no lane in that direction is free, it refuses the request. A granted path stays in place as a circuit until the producer withdraws its request. The path is then released hop by hop.

Every lane carries a request, a destination index, a valid strobe and W data bits in the forward direction. It carries grant, deny and full in the backward direction. Each incoming lane has its own controller and its own two-word input register. Several disjoint paths can therefore be set up and can stream at once. Each hop adds one register stage to the data. The full signal comes from a register, and the input register has a spare slot for the word that is already in flight when backpressure starts. The whole node runs on one clock.

Top module: `stream_switch_node`

## Requirements
- R1: While reset is asserted, and after reset is released, every `src_grant`, `src_deny`, `src_full`, `dst_req` and `dst_valid` bit is low.
- R2: Incoming lanes are numbered as follows: local inputs 0..KI-1, then left lanes, then right lanes. Outgoing lanes use the same order: local outputs 0..KO-1, then left lanes, then right lanes. A destination equal to NODE_ID routes to the local outputs. A larger destination routes to the right lanes, and a smaller one routes to the left lanes.
- R3: A request on an idle incoming lane claims the lowest-numbered free outgoing lane of its group. `dst_req` of that lane rises one cycle later and carries the requested destination on `dst_dest`. No outgoing lane ever has more than one owner.
- R4: If every lane of the group is busy at the edge where the request is evaluated, `src_deny` rises one cycle later and nothing is allocated. The deny is held until the request drops, and it clears one cycle after that.
- R5: When several requests compete in one cycle for the same free lane, the lowest incoming index wins. Local inputs therefore win over left lanes, and left lanes win over right lanes. The losers get no deny in that cycle. They are evaluated again in the next cycle against the updated lane state.
- R6: `src_grant` rises one cycle after the downstream `dst_grant` of the claimed lane is seen. It stays high while the path is active.
- R7: A downstream `dst_deny` on a pending lane raises `src_deny` one cycle later. In that same cycle the lane is freed, so `dst_req` drops.
- R8: A word accepted on an active incoming lane appears on the claimed outgoing lane one cycle later if that lane is not full. Words leave in the order they arrived.
- R9: `dst_valid` is never high while the matching `dst_full` is high. `src_full` goes high when two words are buffered. A producer that obeys `src_full` loses no words.
- R10: When the producer drops its request on an active path and the input register is empty, the outgoing lane is freed at the next edge. `dst_req` and `src_grant` then fall together.
- R11: Paths that share no lane are set up in the same cycle and carry data in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NS | Path request per incoming lane |
| src_dest | input | NS*DW | Destination node index per incoming lane |
| src_valid | input | NS | Data strobe per incoming lane |
| src_data | input | NS*W | Data per incoming lane |
| src_grant | output | NS | Path established, toward the producer |
| src_deny | output | NS | Path refused, toward the producer |
| src_full | output | NS | Backpressure toward the producer |
| dst_req | output | NO | Request per outgoing lane |
| dst_dest | output | NO*DW | Destination carried on each outgoing lane |
| dst_valid | output | NO | Data strobe per outgoing lane |
| dst_data | output | NO*W | Data per outgoing lane |
| dst_grant | input | NO | Grant returned on each outgoing lane |
| dst_deny | input | NO | Deny returned on each outgoing lane |
| dst_full | input | NO | Backpressure on each outgoing lane |

## Verification
If a lane controller holds a wrong state, the fault shows on `dst_req` or on the handshake outputs within one cycle of the request edge. Examples are an output with two owners, a wrong direction decode or a lost release. A routing sweep over every incoming lane and every destination index checks which outgoing lane lights up and which destination it carries. A fault in the input register shows in the streamed data: a dropped, repeated or reordered word. The bench checks this by streaming a numbered sequence while backpressure toggles, and it compares the sequence on arrival.

// File: rtl/stream_switch_node.sv
module stream_switch_node #(
  parameter int N       = 4,
  parameter int NODE_ID = 1,
  parameter int KI      = 1,
  parameter int KO      = 1,
  parameter int KL      = 1,
  parameter int KR      = 2,
  parameter int W       = 8,
  localparam int DW = (N > 1) ? $clog2(N) : 1,
  localparam int NS = KI + KL + KR,
  localparam int NO = KO + KL + KR,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int OW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS-1:0]          src_req,
  input  logic [NS-1:0][DW-1:0]  src_dest,
  input  logic [NS-1:0]          src_valid,
  input  logic [NS-1:0][W-1:0]   src_data,
  output logic [NS-1:0]          src_grant,
  output logic [NS-1:0]          src_deny,
  output logic [NS-1:0]          src_full,
  output logic [NO-1:0]          dst_req,
  output logic [NO-1:0][DW-1:0]  dst_dest,
  output logic [NO-1:0]          dst_valid,
  output logic [NO-1:0][W-1:0]   dst_data,
  input  logic [NO-1:0]          dst_grant,
  input  logic [NO-1:0]          dst_deny,
  input  logic [NO-1:0]          dst_full
);

  localparam logic [1:0] S_IDLE = 2'd0, S_PEND = 2'd1, S_ACT = 2'd2, S_DENY = 2'd3;

  logic [1:0]    st     [NS];
  logic [OW-1:0] sel    [NS];
  logic [DW-1:0] dest_q [NS];
  logic [1:0]    cnt    [NS];
  logic [W-1:0]  b0     [NS];
  logic [W-1:0]  b1     [NS];
  logic [NO-1:0] busy;
  logic [SW-1:0] owner  [NO];

  logic [NS-1:0] claim, deny_now, rel, push, pop;
  logic [OW-1:0] claim_o [NS];
  logic [NO-1:0] busy_n;

  function automatic logic [NO-1:0] group_mask(input logic [DW-1:0] d);
    logic [NO-1:0] m;
    m = '0;
    for (int o = 0; o < NO; o++) begin
      if (int'(d) == NODE_ID) m[o] = (o < KO);
      else if (int'(d) < NODE_ID) m[o] = (o >= KO) && (o < KO + KL);
      else m[o] = (o >= KO + KL);
    end
    return m;
  endfunction

  always_comb begin
    logic [NO-1:0] taken;
    logic [NO-1:0] gm;
    taken = busy;
    for (int s = 0; s < NS; s++) begin
      claim[s]    = 1'b0;
      deny_now[s] = 1'b0;
      claim_o[s]  = '0;
      gm = group_mask(src_dest[s]);
      if (st[s] == S_IDLE && src_req[s]) begin
        if ((~busy & gm) == '0) deny_now[s] = 1'b1;
        else
          for (int o = 0; o < NO; o++)
            if (!claim[s] && gm[o] && !taken[o]) begin
              claim[s]   = 1'b1;
              claim_o[s] = OW'(o);
              taken[o]   = 1'b1;
            end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      rel[s]  = (st[s] == S_PEND && (!src_req[s] || (!dst_grant[sel[s]] && dst_deny[sel[s]])))
             || (st[s] == S_ACT && !src_req[s] && cnt[s] == 2'd0);
      pop[s]  = (st[s] == S_ACT) && (cnt[s] != 2'd0) && !dst_full[sel[s]];
      push[s] = (st[s] == S_ACT) && src_valid[s];
    end
    busy_n = busy;
    for (int s = 0; s < NS; s++) if (rel[s]) busy_n[sel[s]] = 1'b0;
    for (int s = 0; s < NS; s++) if (claim[s]) busy_n[claim_o[s]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int o = 0; o < NO; o++) owner[o] <= '0;
    end else begin
      busy <= busy_n;
      for (int s = 0; s < NS; s++) if (claim[s]) owner[claim_o[s]] <= SW'(s);
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[s] <= S_IDLE; sel[s] <= '0; dest_q[s] <= '0;
        cnt[s] <= 2'd0; b0[s] <= '0; b1[s] <= '0;
      end else begin
        case (st[s])
          S_IDLE: if (claim[s]) begin
                    st[s] <= S_PEND; sel[s] <= claim_o[s]; dest_q[s] <= src_dest[s];
                  end else if (deny_now[s]) st[s] <= S_DENY;
          S_PEND: if (!src_req[s]) st[s] <= S_IDLE;
                  else if (dst_grant[sel[s]]) st[s] <= S_ACT;
                  else if (dst_deny[sel[s]]) st[s] <= S_DENY;
          S_ACT:  if (!src_req[s] && cnt[s] == 2'd0) st[s] <= S_IDLE;
          default: if (!src_req[s]) st[s] <= S_IDLE;
        endcase
        case ({push[s], pop[s]})
          2'b10: begin
            if (cnt[s] == 2'd0) b0[s] <= src_data[s]; else b1[s] <= src_data[s];
            cnt[s] <= cnt[s] + 2'd1;
          end
          2'b01: begin b0[s] <= b1[s]; cnt[s] <= cnt[s] - 2'd1; end
          2'b11: if (cnt[s] == 2'd1) b0[s] <= src_data[s];
                 else begin b0[s] <= b1[s]; b1[s] <= src_data[s]; end
          default: ;
        endcase
      end
    end

    assign src_grant[s] = (st[s] == S_ACT);
    assign src_deny[s]  = (st[s] == S_DENY);
    assign src_full[s]  = (cnt[s] == 2'd2);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      src_full[s] |-> !src_valid[s]);  // R9
    AST_GRANT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_grant[s]) |-> $past(dst_grant[sel[s]]));  // R6
    AST_TEARDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (src_grant[s] && !src_req[s] && cnt[s] == 2'd0) |=> !src_grant[s] && !busy[sel[s]]);  // R10
  end

  for (genvar o = 0; o < NO; o++) begin : g_dst
    logic [SW-1:0] ow;
    logic [NS-1:0] own_m;
    assign ow           = owner[o];
    assign dst_req[o]   = busy[o];
    assign dst_dest[o]  = busy[o] ? dest_q[ow] : '0;
    assign dst_valid[o] = busy[o] && st[ow] == S_ACT && cnt[ow] != 2'd0 && !dst_full[o];
    assign dst_data[o]  = b0[ow];

    always_comb
      for (int s = 0; s < NS; s++)
        own_m[s] = (st[s] == S_PEND || st[s] == S_ACT) && (int'(sel[s]) == o);

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_m) && (busy[o] == |own_m));  // R3
    AST_DENY_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_req[o] && dst_deny[o] && !dst_grant[o] && src_req[ow] && st[ow] == S_PEND) |=> !dst_req[o] || owner[o] != $past(ow));  // R7
  end

endmodule

// File: tb/stream_switch_node_tb.sv
module stream_switch_node_tb;
  localparam int N = 4, ID = 1, KI = 1, KO = 1, KL = 1, KR = 2, W = 8;
  localparam int DW = 2, NS = 4, NO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_req = '0, src_valid = '0, src_grant, src_deny, src_full;
  logic [NS-1:0][DW-1:0] src_dest = '0;
  logic [NS-1:0][W-1:0]  src_data = '0;
  logic [NO-1:0] dst_req, dst_valid, dst_grant = '0, dst_deny = '0, dst_full = '0;
  logic [NO-1:0][DW-1:0] dst_dest;
  logic [NO-1:0][W-1:0]  dst_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stream_switch_node #(.N(N), .NODE_ID(ID), .KI(KI), .KO(KO), .KL(KL), .KR(KR), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_dest(src_dest), .src_valid(src_valid),
    .src_data(src_data), .src_grant(src_grant), .src_deny(src_deny), .src_full(src_full),
    .dst_req(dst_req), .dst_dest(dst_dest), .dst_valid(dst_valid), .dst_data(dst_data),
    .dst_grant(dst_grant), .dst_deny(dst_deny), .dst_full(dst_full));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    src_req = '0; src_valid = '0; dst_grant = '0; dst_deny = '0; dst_full = '0;
    tick(3);
  endtask

  function automatic int expect_out(input int d);
    if (d == ID) return 0;
    if (d < ID) return KO;
    return KO + KL;
  endfunction

  initial begin
    if (cyc > 20000) ;
    wait (cyc > 20000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int sent, rx, k, first_tx, first_rx;
    bit bad_valid;
    tick(2);
    chk({src_grant, src_deny, src_full, dst_req, dst_valid} == '0, "R1 in reset",
        int'({src_grant, src_deny, src_full, dst_req, dst_valid}), 0);
    rst_n = 1'b1;
    tick(2);
    chk({src_grant, src_deny, src_full, dst_req, dst_valid} == '0, "R1 after reset",
        int'({src_grant, src_deny, src_full, dst_req, dst_valid}), 0);

    // R2 / R3 routing sweep over every incoming lane and destination
    for (int s = 0; s < NS; s++)
      for (int d = 0; d < N; d++) begin
        int e;
        e = expect_out(d);
        src_dest[s] = DW'(d); src_req[s] = 1'b1;
        tick();
        chk(dst_req == NO'(1 << e) && int'(dst_dest[e]) == d, "R2 route", int'(dst_req), 1 << e);
        src_req[s] = 1'b0;
        tick();
        chk(dst_req == '0, "R3 release pending", int'(dst_req), 0);
      end

    // R3 lowest free lane, R4 deny when group busy
    src_dest[0] = 2'd3; src_dest[1] = 2'd2; src_req[0] = 1'b1; src_req[1] = 1'b1;
    tick();
    chk(dst_req == 4'b1100 && dst_dest[2] == 2'd3 && dst_dest[3] == 2'd2, "R3 two right lanes",
        int'(dst_req), 'hC);
    src_dest[3] = 2'd2; src_req[3] = 1'b1;
    tick();
    chk(src_deny == 4'b1000 && dst_req == 4'b1100, "R4 deny no alloc", int'(src_deny), 8);
    tick();
    chk(src_deny == 4'b1000, "R4 deny held", int'(src_deny), 8);
    src_req[3] = 1'b0;
    tick();
    chk(src_deny == '0, "R4 deny clears", int'(src_deny), 0);
    quiesce();

    // R5 priority: local, left, right all want the single local output
    src_dest[0] = 2'd1; src_dest[1] = 2'd1; src_dest[2] = 2'd1;
    src_req[2:0] = 3'b111;
    tick();
    chk(dst_req == 4'b0001 && src_deny == '0, "R5 losers not denied", int'(src_deny), 0);
    dst_grant[0] = 1'b1;
    tick();
    chk(src_grant == 4'b0001, "R5 local wins", int'(src_grant), 1);
    chk(src_deny == 4'b0110, "R5 losers re-evaluated", int'(src_deny), 6);
    quiesce();
    src_dest[1] = 2'd1; src_dest[2] = 2'd1; src_req[2:1] = 2'b11; dst_grant[0] = 1'b1;
    tick(2);
    chk(src_grant == 4'b0010, "R5 left over right", int'(src_grant), 2);
    quiesce();

    // R7 downstream deny
    src_dest[0] = 2'd3; src_req[0] = 1'b1;
    tick();
    dst_deny[2] = 1'b1;
    tick();
    chk(src_deny[0] && !dst_req[2], "R7 deny and free", int'({src_deny[0], dst_req[2]}), 2);
    quiesce();

    // R6 grant latency, R8/R9 streaming with backpressure, R10 teardown
    src_dest[0] = 2'd3; src_req[0] = 1'b1;
    tick();
    dst_grant[2] = 1'b1;
    chk(src_grant[0] == 1'b0, "R6 no grant yet", int'(src_grant[0]), 0);
    tick();
    chk(src_grant[0] == 1'b1, "R6 grant one cycle later", int'(src_grant[0]), 1);
    sent = 0; rx = 0; k = 0; first_tx = -1; first_rx = -1; bad_valid = 1'b0;
    while (rx < 16 && k < 200) begin
      dst_full[2] = (k >= 3) && ((k % 5) < 3);
      if (!src_full[0] && sent < 16) begin
        src_valid[0] = 1'b1; src_data[0] = W'(8'h40 + sent);
        if (first_tx < 0) first_tx = k;
        sent++;
      end else src_valid[0] = 1'b0;
      #1;
      if (dst_valid[2] && dst_full[2]) bad_valid = 1'b1;
      if (dst_valid[2]) begin
        if (first_rx < 0) first_rx = k;
        chk(int'(dst_data[2]) == 'h40 + rx, "R8 order", int'(dst_data[2]), 'h40 + rx);
        rx++;
      end
      tick(); k++;
    end
    src_valid[0] = 1'b0;
    chk(first_rx - first_tx == 1, "R8 one stage latency", first_rx - first_tx, 1);
    chk(rx == 16 && sent == 16, "R9 no word lost", rx, 16);
    chk(!bad_valid, "R9 valid blocked by full", int'(bad_valid), 0);
    dst_full[2] = 1'b0;
    src_req[0] = 1'b0;
    tick();
    chk(!dst_req[2] && !src_grant[0], "R10 teardown", int'({dst_req[2], src_grant[0]}), 0);
    quiesce();

    // R11 two disjoint paths at once
    src_dest[0] = 2'd3; src_dest[1] = 2'd1; src_req[1:0] = 2'b11;
    tick();
    chk(dst_req == 4'b0101, "R11 parallel setup", int'(dst_req), 5);
    dst_grant[0] = 1'b1; dst_grant[2] = 1'b1;
    tick();
    chk(src_grant == 4'b0011, "R11 both granted", int'(src_grant), 3);
    src_valid[1:0] = 2'b11; src_data[0] = 8'hA1; src_data[1] = 8'hB2;
    tick();
    src_valid = '0;
    chk(dst_valid == 4'b0101 && dst_data[2] == 8'hA1 && dst_data[0] == 8'hB2, "R11 parallel data",
        int'(dst_valid), 5);
    quiesce();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule